// File: doc/BRIEF.md
# Serial Flash Security-Register Programmer

This block is the command handler that a serial flash model uses to write its three one-time-programmable security registers of 256 bytes each. It watches a mode 0 or mode 3 SPI slave stream (chip select, serial clock, serial data in), oversampled by the system clock through a synchronizer. It recognises the security-register program command and decodes the address that follows. The incoming data bytes are collected in a staging buffer. When the frame closes cleanly, the staged bytes are burned into the selected register. The write-enable latch then receives a one-cycle clear pulse.

Programming can only clear bits. Each stored byte becomes its old value ANDed with the new data, so a register that is never erased keeps its history. A per-register lock input blocks all writes to that register. A separate combinational read port exposes the stored bytes to the rest of the flash model.

The controller is a single state machine with these states:

- `ST_IDLE`: wait for a chip-select falling edge.
- `ST_OPCODE`: collect the command byte.
- `ST_ADDR`: collect 3 or 4 address bytes.
- `ST_DATA`: stage data bytes.
- `ST_SKIP`: swallow a rejected frame until chip select rises.
- `ST_PROGRAM`: walk the staging buffer and burn the staged bytes, one per clock.

Its transitions are:

- IDLE→OPCODE on a chip-select fall.
- OPCODE→ADDR on opcode 0x42 with the latch set; OPCODE→SKIP otherwise.
- ADDR→DATA on a valid, unlocked address; ADDR→SKIP otherwise.
- DATA→PROGRAM on a clean close; DATA→IDLE on any other close.
- PROGRAM→IDLE after the last buffer index.
- OPCODE, ADDR and SKIP each return to IDLE when chip select rises.

A frame whose chip select falls during `ST_PROGRAM` is never seen, because IDLE only starts on a fresh falling edge.

Top module: `secreg_prog`

## Requirements
- R1: After reset, every byte of every register reads 0xFF, and both `busy` and `wel_clr` are low.
- R2: The command byte is 0x42. It is taken MSB first on rising serial-clock edges while chip select is low, with the clock idling either low (mode 0) or high (mode 3). Any other command byte leaves the registers unchanged.
- R3: A command that arrives while `wel` is low changes nothing.
- R4: The address follows the command byte MSB first. It is 3 bytes when `addr4_mode` is 0 and 4 bytes when it is 1. Address bits 31:16 (or 23:16 in 3-byte form) must be zero, or the command changes nothing.
- R5: Address bits 15:12 select the register: values 1, 2 and 3 pick register 1, 2 and 3. Any other value, or a nonzero bits 11:8, makes the command change nothing. On the read port, `rd_sel` 0, 1 and 2 show registers 1, 2 and 3, and `rd_sel` 3 reads 0xFF.
- R6: `lock_bits[n]` set blocks every write to register n+1 (bit 0 is register 1). The other registers stay programmable.
- R7: A programmed byte becomes the old stored value ANDed with the data byte.
- R8: Address bits 7:0 give the first byte address. It increments after each data byte and wraps from 255 to 0 within the selected register.
- R9: Data is written only when chip select rises after at least one data byte and on a byte boundary. A frame with no data byte, or one ending mid-byte, changes nothing.
- R10: A committed command holds `busy` high for exactly 256 cycles. `wel_clr` is high for exactly one cycle, the last busy cycle. An ignored command raises neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial clock |
| di | input | 1 | Serial data in |
| wel | input | 1 | Write-enable latch state |
| lock_bits | input | 3 | Per-register permanent lock, bit 0 = register 1 |
| addr4_mode | input | 1 | 1 selects a 4-byte address |
| rd_sel | input | 2 | Read port register select (0..2) |
| rd_addr | input | 8 | Read port byte address |
| rd_data | output | 8 | Stored byte at `rd_sel`/`rd_addr` |
| busy | output | 1 | High while staged bytes are being burned |
| wel_clr | output | 1 | One-cycle pulse that clears the write-enable latch |

## Verification
The assertions assume the following about the inputs:

- `wel` and `lock_bits` hold steady from the command byte until the burn finishes.
- Chip select stays high for several clocks after a frame closes.
- Each serial-clock phase lasts longer than the synchronizer delay.

The stimulus keeps within these limits. It drives every serial half-period over four system clocks and changes `wel` and the locks only between frames. It also waits well beyond the 256-cycle burn before starting the next frame, so no frame is ever dropped during `busy`.

// File: rtl/secreg_pkg.sv
package secreg_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_ADDR,
        ST_DATA,
        ST_SKIP,
        ST_PROGRAM
    } fsm_state_t;

endpackage

// File: rtl/secreg_spi_rx.sv
module secreg_spi_rx #(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       di,
    output logic       frame_start,
    output logic       frame_end,
    output logic       byte_stb,
    output logic [7:0] byte_val,
    output logic       on_boundary
);

    logic [SYNC_STAGES-1:0] cs_sr, sck_sr, di_sr;
    logic                   cs_prev, sck_prev;
    logic                   cs_now, sck_now, di_now, sck_rise;
    logic [2:0]             bit_cnt;
    logic [6:0]             shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_sr    <= '1;
            sck_sr   <= '0;
            di_sr    <= '0;
            cs_prev  <= 1'b1;
            sck_prev <= 1'b0;
        end else begin
            cs_sr    <= {cs_sr[SYNC_STAGES-2:0], cs_n};
            sck_sr   <= {sck_sr[SYNC_STAGES-2:0], sclk};
            di_sr    <= {di_sr[SYNC_STAGES-2:0], di};
            cs_prev  <= cs_now;
            sck_prev <= sck_now;
        end
    end

    assign cs_now      = cs_sr[SYNC_STAGES-1];
    assign sck_now     = sck_sr[SYNC_STAGES-1];
    assign di_now      = di_sr[SYNC_STAGES-1];
    assign frame_start = cs_prev & ~cs_now;
    assign frame_end   = ~cs_prev & cs_now;
    assign sck_rise    = ~cs_now & sck_now & ~sck_prev;
    assign on_boundary = (bit_cnt == 3'd0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            byte_stb <= 1'b0;
            byte_val <= '0;
        end else begin
            byte_stb <= 1'b0;
            if (frame_start) begin
                bit_cnt <= '0;
            end else if (sck_rise) begin
                bit_cnt <= bit_cnt + 3'd1;
                shreg   <= {shreg[5:0], di_now};
                if (bit_cnt == 3'd7) begin
                    byte_stb <= 1'b1;
                    byte_val <= {shreg, di_now};
                end
            end
        end
    end

endmodule

// File: rtl/secreg_page_buf.sv
module secreg_page_buf #(
    parameter int DEPTH = 256,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data,
    output logic             rd_valid
);

    logic [7:0]       slots [DEPTH];
    logic [DEPTH-1:0] filled;

    always_ff @(posedge clk) begin
        if (wr_en) slots[wr_idx] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled <= '0;
        end else if (clear) begin
            filled <= '0;
        end else if (wr_en) begin
            filled[wr_idx] <= 1'b1;
        end
    end

    assign rd_data  = slots[rd_idx];
    assign rd_valid = filled[rd_idx];

endmodule

// File: rtl/secreg_otp_bank.sv
module secreg_otp_bank #(
    parameter int REG_COUNT = 3,
    parameter int REG_BYTES = 256,
    localparam int IDX_W = $clog2(REG_BYTES),
    localparam int SEL_W = $clog2(REG_COUNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             prog_en,
    input  logic [SEL_W-1:0] prog_sel,
    input  logic [IDX_W-1:0] prog_idx,
    input  logic [7:0]       prog_data,
    input  logic [SEL_W-1:0] rd_sel,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);

    logic [7:0] rd_each [REG_COUNT];

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        logic [7:0] cells [REG_BYTES];
        logic       hit;

        assign hit = prog_en && (int'(prog_sel) == g);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < REG_BYTES; i++) cells[i] <= 8'hFF;
            end else if (hit) begin
                cells[prog_idx] <= cells[prog_idx] & prog_data;
            end
        end

        assign rd_each[g] = cells[rd_idx];
    end

    always_comb begin
        rd_data = 8'hFF;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (int'(rd_sel) == i) rd_data = rd_each[i];
        end
    end

endmodule

// File: rtl/secreg_prog.sv
module secreg_prog
    import secreg_pkg::*;
#(
    parameter int         REG_COUNT   = 3,
    parameter int         REG_BYTES   = 256,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] CMD_CODE    = 8'h42,
    localparam int IDX_W = $clog2(REG_BYTES),
    localparam int SEL_W = $clog2(REG_COUNT + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs_n,
    input  logic                 sclk,
    input  logic                 di,
    input  logic                 wel,
    input  logic [REG_COUNT-1:0] lock_bits,
    input  logic                 addr4_mode,
    input  logic [SEL_W-1:0]     rd_sel,
    input  logic [IDX_W-1:0]     rd_addr,
    output logic [7:0]           rd_data,
    output logic                 busy,
    output logic                 wel_clr
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(REG_BYTES - 1);

    logic             frame_start, frame_end, byte_stb, on_boundary;
    logic [7:0]       byte_val;
    fsm_state_t       state_q, state_d;
    logic [23:0]      addr_sh;
    logic [2:0]       addr_left;
    logic [SEL_W-1:0] sel_q;
    logic [IDX_W-1:0] ptr_q, prog_idx;
    logic             have_byte;
    logic [31:0]      addr_full;
    logic [3:0]       sel_field;
    logic             sel_ok, lock_hit, addr_ok, last_addr;
    logic             buf_clear, buf_we, buf_rd_valid;
    logic [7:0]       buf_rd_data;
    logic             prog_we;
    logic [SEL_W-1:0] prog_sel;

    secreg_spi_rx #(.SYNC_STAGES(SYNC_STAGES)) u_rx (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
        .frame_start(frame_start), .frame_end(frame_end),
        .byte_stb(byte_stb), .byte_val(byte_val), .on_boundary(on_boundary)
    );

    secreg_page_buf #(.DEPTH(REG_BYTES)) u_buf (
        .clk(clk), .rst_n(rst_n), .clear(buf_clear),
        .wr_en(buf_we), .wr_idx(ptr_q), .wr_data(byte_val),
        .rd_idx(prog_idx), .rd_data(buf_rd_data), .rd_valid(buf_rd_valid)
    );

    secreg_otp_bank #(.REG_COUNT(REG_COUNT), .REG_BYTES(REG_BYTES)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .prog_en(prog_we), .prog_sel(prog_sel), .prog_idx(prog_idx),
        .prog_data(buf_rd_data),
        .rd_sel(rd_sel), .rd_idx(rd_addr), .rd_data(rd_data)
    );

    // Address decode on the final address byte
    assign addr_full = {addr_sh, byte_val};
    assign sel_field = addr_full[15:12];
    assign last_addr = (addr_left == 3'd1);

    always_comb begin
        sel_ok   = 1'b0;
        lock_hit = 1'b0;
        for (int i = 0; i < REG_COUNT; i++) begin
            if (int'(sel_field) == i + 1) begin
                sel_ok   = 1'b1;
                lock_hit = lock_bits[i];
            end
        end
    end

    assign addr_ok = (addr_full[31:16] == 16'h0) && (addr_full[11:8] == 4'h0)
                     && sel_ok && !lock_hit;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (frame_start) state_d = ST_OPCODE;
            ST_OPCODE: begin
                if (frame_end)     state_d = ST_IDLE;
                else if (byte_stb) state_d = (byte_val == CMD_CODE && wel) ? ST_ADDR : ST_SKIP;
            end
            ST_ADDR: begin
                if (frame_end)                  state_d = ST_IDLE;
                else if (byte_stb && last_addr) state_d = addr_ok ? ST_DATA : ST_SKIP;
            end
            ST_DATA: begin
                if (frame_end) state_d = (on_boundary && have_byte) ? ST_PROGRAM : ST_IDLE;
            end
            ST_SKIP:    if (frame_end) state_d = ST_IDLE;
            ST_PROGRAM: if (prog_idx == LAST_IDX) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        wel_clr   = 1'b0;
        buf_clear = 1'b0;
        buf_we    = 1'b0;
        prog_we   = 1'b0;
        prog_sel  = sel_q;
        unique case (state_q)
            ST_ADDR:    buf_clear = byte_stb && last_addr && addr_ok;
            ST_DATA:    buf_we    = byte_stb;
            ST_PROGRAM: begin
                busy    = 1'b1;
                prog_we = buf_rd_valid;
                wel_clr = (prog_idx == LAST_IDX);
            end
            default: ;
        endcase
    end

    // Datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_sh   <= '0;
            addr_left <= '0;
            sel_q     <= '0;
            ptr_q     <= '0;
            prog_idx  <= '0;
            have_byte <= 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (frame_start) addr_sh <= '0;
                ST_OPCODE: if (byte_stb) addr_left <= addr4_mode ? 3'd4 : 3'd3;
                ST_ADDR: if (byte_stb) begin
                    addr_sh   <= addr_full[23:0];
                    addr_left <= addr_left - 3'd1;
                    if (last_addr) begin
                        ptr_q     <= addr_full[IDX_W-1:0];
                        sel_q     <= SEL_W'(sel_field - 4'd1);
                        have_byte <= 1'b0;
                    end
                end
                ST_DATA: begin
                    if (byte_stb) begin
                        ptr_q     <= ptr_q + 1'b1;
                        have_byte <= 1'b1;
                    end
                    prog_idx <= '0;
                end
                ST_PROGRAM: prog_idx <= prog_idx + 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/secreg_prog_chk.sv
module secreg_prog_chk #(
    parameter int REG_COUNT = 3,
    localparam int SEL_W = $clog2(REG_COUNT + 1)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 wel,
    input logic [REG_COUNT-1:0] lock_bits,
    input logic                 busy,
    input logic                 wel_clr,
    input logic                 prog_we,
    input logic [SEL_W-1:0]     prog_sel
);

    // R10
    welclr_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |=> !wel_clr);

    // R10
    welclr_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wel_clr |-> busy);

    // R10
    busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(wel_clr));

    // R3
    wel_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> wel);

    // R9
    frame_closed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> cs_n);

    // R5
    sel_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> (int'(prog_sel) < REG_COUNT));

    // R6
    lock_respect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> !lock_bits[prog_sel]);

    // R7
    write_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_we |-> busy);

endmodule

bind secreg_prog secreg_prog_chk #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .wel(wel), .lock_bits(lock_bits),
    .busy(busy), .wel_clr(wel_clr), .prog_we(prog_we), .prog_sel(prog_sel)
);

// File: tb/secreg_prog_test.sv
module secreg_prog_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, sclk = 1'b0, di = 1'b0;
    logic       wel = 1'b1, addr4_mode = 1'b0;
    logic [2:0] lock_bits = 3'b000;
    logic [1:0] rd_sel = '0;
    logic [7:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       busy, wel_clr;

    int checks = 0, errors = 0;
    int busy_cyc = 0, pulse_cyc = 0;
    bit cmp_en = 1'b0;
    string cur_tag = "R1";
    int sweep = 0;
    logic [7:0] ref_mem [3][256];

    always #10 clk = ~clk;

    secreg_prog uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .di(di),
        .wel(wel), .lock_bits(lock_bits), .addr4_mode(addr4_mode),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .wel_clr(wel_clr)
    );

    task automatic check(string tag, int act, int exp, string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Per-clock comparison of the read port against the reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (busy) busy_cyc++;
            if (wel_clr) pulse_cyc++;
            if (cmp_en) begin
                check(cur_tag, int'(rd_data),
                      (rd_sel == 2'd3) ? 8'hFF : int'(ref_mem[rd_sel][rd_addr]),
                      $sformatf("read sel %0d addr %0d", rd_sel, rd_addr));
                sweep = (sweep + 1) % 1024;
                rd_sel  = 2'(sweep / 256);
                rd_addr = 8'(sweep % 256);
            end
        end
    end

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(logic [7:0] b, int nbits);
        for (int i = 7; i > 7 - nbits; i--) begin
            sclk = 1'b0;
            di   = b[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
        end
    endtask

    task automatic run_cmd(string tag, bit mode3, logic [7:0] op, logic [31:0] addr,
                           logic [7:0] data[$], int tail_bits);
        int  nab;
        int  sel;
        bit  ok;
        int  b0, p0;
        logic [7:0] staged [256];
        bit  staged_v [256];
        nab = addr4_mode ? 4 : 3;
        sel = int'(addr[15:12]);
        ok  = (op == 8'h42) && wel && (addr[31:16] == 16'h0) && (addr[11:8] == 4'h0)
              && (sel >= 1) && (sel <= 3) && (data.size() > 0) && (tail_bits == 0);
        if (ok) ok = !lock_bits[sel-1];
        cmp_en = 1'b0;
        cur_tag = tag;
        b0 = busy_cyc;
        p0 = pulse_cyc;
        sclk = mode3;
        wait_clk(4);
        cs_n = 1'b0;
        wait_clk(4);
        send_bits(op, 8);
        for (int k = nab - 1; k >= 0; k--) send_bits(addr[8*k +: 8], 8);
        foreach (data[k]) send_bits(data[k], 8);
        if (tail_bits > 0) send_bits(8'hFF, tail_bits);
        if (!mode3) sclk = 1'b0;
        wait_clk(4);
        cs_n = 1'b1;
        wait_clk(600);
        check("R10", busy_cyc - b0, ok ? 256 : 0, {tag, " busy cycles"});
        check("R10", pulse_cyc - p0, ok ? 1 : 0, {tag, " wel_clr cycles"});
        if (ok) begin
            foreach (staged_v[k]) staged_v[k] = 1'b0;
            foreach (data[k]) begin
                staged[(int'(addr[7:0]) + k) % 256]   = data[k];
                staged_v[(int'(addr[7:0]) + k) % 256] = 1'b1;
            end
            for (int k = 0; k < 256; k++)
                if (staged_v[k]) ref_mem[sel-1][k] = ref_mem[sel-1][k] & staged[k];
        end
        cmp_en = 1'b1;
        wait_clk(1030);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int r = 0; r < 3; r++)
            for (int a = 0; a < 256; a++) ref_mem[r][a] = 8'hFF;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(3);
        // R1 reset state
        check("R1", int'(busy), 0, "busy after reset");
        check("R1", int'(wel_clr), 0, "wel_clr after reset");
        cur_tag = "R1";
        cmp_en  = 1'b1;
        wait_clk(1030);

        // R2 mode 0 program, reg1
        run_cmd("R2", 1'b0, 8'h42, 32'h0000_1010, '{8'hAA, 8'h55}, 0);
        // R7 AND over existing contents
        run_cmd("R7", 1'b0, 8'h42, 32'h0000_1010, '{8'h0F}, 0);
        // R8 wrap 255 -> 0 in reg2
        run_cmd("R8", 1'b0, 8'h42, 32'h0000_20FE, '{8'h11, 8'h22, 8'h33, 8'h44}, 0);
        // R3 latch clear: ignored
        wel = 1'b0;
        run_cmd("R3", 1'b0, 8'h42, 32'h0000_2000, '{8'h00}, 0);
        wel = 1'b1;
        // R6 locked reg3 ignored, reg1 still writable
        lock_bits = 3'b100;
        run_cmd("R6", 1'b0, 8'h42, 32'h0000_3005, '{8'h00}, 0);
        run_cmd("R6", 1'b0, 8'h42, 32'h0000_1040, '{8'h3C}, 0);
        lock_bits = 3'b000;
        // R5 invalid selects
        run_cmd("R5", 1'b0, 8'h42, 32'h0000_4000, '{8'h00}, 0);
        run_cmd("R5", 1'b0, 8'h42, 32'h0000_1100, '{8'h00}, 0);
        run_cmd("R5", 1'b0, 8'h42, 32'h0000_0000, '{8'h00}, 0);
        // R4 address width and upper bits
        addr4_mode = 1'b1;
        run_cmd("R4", 1'b1, 8'h42, 32'h0000_3080, '{8'h5A}, 0);
        run_cmd("R4", 1'b0, 8'h42, 32'h0100_3081, '{8'h00}, 0);
        addr4_mode = 1'b0;
        run_cmd("R4", 1'b0, 8'h42, 32'h0001_3082, '{8'h00}, 0);
        // R9 partial final byte, no data byte
        run_cmd("R9", 1'b0, 8'h42, 32'h0000_2010, '{8'h01, 8'h02}, 3);
        run_cmd("R9", 1'b0, 8'h42, 32'h0000_2010, '{}, 0);
        // R2 wrong opcode, then mode 3
        run_cmd("R2", 1'b0, 8'h02, 32'h0000_2030, '{8'h00}, 0);
        run_cmd("R2", 1'b1, 8'h42, 32'h0000_2030, '{8'hC3}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule